// File: doc/BRIEF.md
# I2C Bit and Condition Timing Generator

This block produces the SCL waveform and the SDA change instants for an I2C master from a single input clock. A byte sequencer above it issues one primitive at a time: a data or acknowledge bit, a START, a STOP or a repeated START. The block then drives the open-drain enables of both lines with the programmed phase lengths. It reports the end of each primitive with a one-clock strobe. It also samples SDA in the middle of every SCL high phase and hands that value back with a one-clock valid pulse.

Timing comes from a 32-bit divider word and three small selectors. The word carries a low divisor in its lower half and a high divisor in its upper half, and each divisor is used plus one. Each SCL phase consists of eight sub-phases of its divisor. The SDA update point falls at a selectable eighth of the low phase. START and STOP setup and hold times are multiples of eight high-divisor units. All timing inputs are captured when a primitive is accepted, so software may rewrite them while a primitive runs.

Top module: `i2c_phase_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, scl_oe and sda_oe are 0 (both lines released), cmd_ready is 1, and rx_valid, bit_done, start_done and stop_done are 0.
- R2: With l = div_word[15:0] + 1 and h = div_word[31:16] + 1, a bit primitive (cmd_op = 2'b00), accepted on clock edge t while SCL is held low, keeps scl_oe at 1 until edge t + 8·l. At that edge scl_oe becomes 0. At edge t + 8·l + 8·h it returns to 1, and bit_done pulses for exactly that one cycle.
- R3: With s = upd_sel + 1 (1 to 8), a bit primitive sets sda_oe to the inverse of cmd_bit at edge t + s·l. That leaves (8 − s)·l clocks before SCL is released. When s = 8 both lines change on the same edge.
- R4: sda_oe does not change while SCL is released during a bit primitive.
- R5: In every bit primitive, rx_valid pulses exactly once, one cycle long, on edge t + 8·l + 4·h. rx_bit then holds the sda_in value present at that edge.
- R6: A START (cmd_op = 2'b01) accepted on edge t from an idle bus works as follows, with u = sta_sel + 1. sda_oe rises at edge t + 8·h·u. scl_oe rises 8·h·(u + 1) clocks later, and start_done pulses on that same edge.
- R7: A repeated START (cmd_op = 2'b11) accepted on edge t with SCL held low releases SDA at edge t and releases SCL at edge t + 4·l. From that edge it follows the START timing of R6.
- R8: A STOP (cmd_op = 2'b10) accepted on edge t with SCL held low drives SDA low at edge t and releases SCL at edge t + 4·l. With p = sto_sel + 1, it releases SDA 8·h·p clocks later, and stop_done pulses on that same edge.
- R9: A command is accepted only on an edge where cmd_ready is 1. cmd_valid pulses while a primitive runs are ignored and start no further primitive.
- R10: div_word, upd_sel, sta_sel and sto_sel are captured on the accepting edge. Changing them while the primitive runs has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock from which all timing is counted |
| rst | input | 1 | Synchronous active-high reset |
| div_word | input | 32 | High divisor in bits 31:16, low divisor in bits 15:0 |
| upd_sel | input | 3 | SDA update point within the low phase, in eighths minus one |
| sta_sel | input | 2 | START setup multiplier minus one |
| sto_sel | input | 2 | STOP setup multiplier minus one |
| cmd_valid | input | 1 | Request to start a primitive |
| cmd_op | input | 2 | 00 bit, 01 START, 10 STOP, 11 repeated START |
| cmd_bit | input | 1 | Bit value to place on SDA (1 releases SDA) |
| cmd_ready | output | 1 | High when idle and able to accept a command |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 drives SCL low, 0 releases it |
| sda_oe | output | 1 | 1 drives SDA low, 0 releases it |
| rx_valid | output | 1 | One-cycle strobe marking a fresh SDA sample |
| rx_bit | output | 1 | SDA value sampled at mid high phase |
| bit_done | output | 1 | One-cycle strobe at the end of a bit |
| start_done | output | 1 | One-cycle strobe when a START or repeated START completes |
| stop_done | output | 1 | One-cycle strobe when a STOP completes |

## Verification
The bench runs whole transactions: START, a run of bits, an occasional repeated START with more bits, then STOP. Each primitive draws its own divisors and selectors. Unequal low and high divisors catch a swapped half of the divider word. The sweep of the SDA update point, including both end values, separates the hold segment from the setup segment and catches an off-by-one in either. Every command is followed by a scramble of all timing inputs and a stray command pulse. These show that timing stays latched and that busy-time requests are dropped. Random sda_in levels, held across each bit, confirm that the mid-high sample reaches rx_bit.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

    // divisor width and derived widths
    localparam int DIV_W  = 16;
    localparam int WORD_W = 2 * DIV_W;
    localparam int UPD_W  = 3;
    localparam int SET_W  = 2;
    // 8 * (2^DIV_W) * (2^SET_W + 1) fits in DIV_W + 7 bits
    localparam int TMR_W  = DIV_W + 7;

    typedef enum logic [1:0] {
        OP_BIT     = 2'b00,
        OP_START   = 2'b01,
        OP_STOP    = 2'b10,
        OP_RESTART = 2'b11
    } tg_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOW_A,
        ST_LOW_B,
        ST_HIGH,
        ST_RS_LOW,
        ST_STA_SU,
        ST_STA_HD,
        ST_SP_LOW,
        ST_STO_SU
    } tg_state_e;

    // divisors and multipliers with the implicit +1 applied
    typedef struct packed {
        logic [DIV_W:0]   lo;
        logic [DIV_W:0]   hi;
        logic [UPD_W:0]   s;
        logic [SET_W:0]   u;
        logic [SET_W:0]   p;
    } tg_cfg_t;

    // clocks from SCL fall (bit accept) to the SDA update
    function automatic logic [TMR_W-1:0] seg_hold(tg_cfg_t c);
        return TMR_W'(c.lo) * TMR_W'(c.s);
    endfunction

    // clocks from the SDA update to SCL release
    function automatic logic [TMR_W-1:0] seg_setup(tg_cfg_t c);
        return TMR_W'(c.lo) * (TMR_W'(4'd8) - TMR_W'(c.s));
    endfunction

    function automatic logic [TMR_W-1:0] seg_high(tg_cfg_t c);
        return TMR_W'(c.hi) << 3;
    endfunction

    // timer value seen on the edge that lies 4*h clocks into the high phase
    function automatic logic [TMR_W-1:0] seg_mid(tg_cfg_t c);
        return (TMR_W'(c.hi) << 2) + TMR_W'(1);
    endfunction

    function automatic logic [TMR_W-1:0] seg_pre(tg_cfg_t c);
        return TMR_W'(c.lo) << 2;
    endfunction

    function automatic logic [TMR_W-1:0] seg_sta_su(tg_cfg_t c);
        return (TMR_W'(c.hi) * TMR_W'(c.u)) << 3;
    endfunction

    function automatic logic [TMR_W-1:0] seg_sta_hd(tg_cfg_t c);
        return (TMR_W'(c.hi) * (TMR_W'(c.u) + TMR_W'(1))) << 3;
    endfunction

    function automatic logic [TMR_W-1:0] seg_sto_su(tg_cfg_t c);
        return (TMR_W'(c.hi) * TMR_W'(c.p)) << 3;
    endfunction

endpackage

// File: rtl/tg_cfg_latch.sv
module tg_cfg_latch
    import i2c_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [WORD_W-1:0] div_word,
    input  logic [UPD_W-1:0]  upd_sel,
    input  logic [SET_W-1:0]  sta_sel,
    input  logic [SET_W-1:0]  sto_sel,
    output tg_cfg_t           cfg_live,
    output tg_cfg_t           cfg_q
);

    always_comb begin
        cfg_live.lo = {1'b0, div_word[DIV_W-1:0]} + (DIV_W+1)'(1);
        cfg_live.hi = {1'b0, div_word[WORD_W-1:DIV_W]} + (DIV_W+1)'(1);
        cfg_live.s  = {1'b0, upd_sel} + (UPD_W+1)'(1);
        cfg_live.u  = {1'b0, sta_sel} + (SET_W+1)'(1);
        cfg_live.p  = {1'b0, sto_sel} + (SET_W+1)'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (capture) begin
            cfg_q <= cfg_live;
        end
    end

endmodule

// File: rtl/tg_seg_timer.sv
module tg_seg_timer
    import i2c_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic [TMR_W-1:0] remain,
    output logic             expire
);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - TMR_W'(1);
        end
    end

    // a segment loaded with N ends on the N-th edge after the load
    assign expire = (remain == TMR_W'(1));

    // R3: the phase logic must never schedule an empty segment (s = 8 case)
    a_r3_no_empty_segment: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

endmodule

// File: rtl/tg_phase_fsm.sv
module tg_phase_fsm
    import i2c_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  tg_op_e           cmd_op,
    input  logic             cmd_bit,
    input  logic             sda_in,
    input  tg_cfg_t          cfg_live,
    input  tg_cfg_t          cfg_q,
    input  logic [TMR_W-1:0] remain,
    input  logic             expire,
    output logic             load,
    output logic [TMR_W-1:0] load_val,
    output logic             accept,
    output logic             cmd_ready,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             rx_valid,
    output logic             rx_bit,
    output logic             bit_done,
    output logic             start_done,
    output logic             stop_done
);

    tg_state_e state, state_n;
    logic      bit_q;
    logic      scl_n, sda_n, rxv_n, bd_n, sd_n, pd_n;

    assign cmd_ready = (state == ST_IDLE);

    always_comb begin
        state_n  = state;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        scl_n    = scl_oe;
        sda_n    = sda_oe;
        rxv_n    = 1'b0;
        bd_n     = 1'b0;
        sd_n     = 1'b0;
        pd_n     = 1'b0;
        case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    case (cmd_op)
                        OP_BIT: begin
                            state_n  = ST_LOW_A;
                            load_val = seg_hold(cfg_live);
                        end
                        OP_START: begin
                            state_n  = ST_STA_SU;
                            load_val = seg_sta_su(cfg_live);
                        end
                        OP_STOP: begin
                            sda_n    = 1'b1;
                            state_n  = ST_SP_LOW;
                            load_val = seg_pre(cfg_live);
                        end
                        default: begin
                            sda_n    = 1'b0;
                            state_n  = ST_RS_LOW;
                            load_val = seg_pre(cfg_live);
                        end
                    endcase
                end
            end
            ST_LOW_A: begin
                if (expire) begin
                    sda_n = ~bit_q;
                    load  = 1'b1;
                    if (seg_setup(cfg_q) == '0) begin
                        scl_n    = 1'b0;
                        state_n  = ST_HIGH;
                        load_val = seg_high(cfg_q);
                    end else begin
                        state_n  = ST_LOW_B;
                        load_val = seg_setup(cfg_q);
                    end
                end
            end
            ST_LOW_B: begin
                if (expire) begin
                    scl_n    = 1'b0;
                    state_n  = ST_HIGH;
                    load     = 1'b1;
                    load_val = seg_high(cfg_q);
                end
            end
            ST_HIGH: begin
                if (remain == seg_mid(cfg_q)) begin
                    rxv_n = 1'b1;
                end
                if (expire) begin
                    scl_n   = 1'b1;
                    bd_n    = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            ST_RS_LOW: begin
                if (expire) begin
                    scl_n    = 1'b0;
                    state_n  = ST_STA_SU;
                    load     = 1'b1;
                    load_val = seg_sta_su(cfg_q);
                end
            end
            ST_STA_SU: begin
                if (expire) begin
                    sda_n    = 1'b1;
                    state_n  = ST_STA_HD;
                    load     = 1'b1;
                    load_val = seg_sta_hd(cfg_q);
                end
            end
            ST_STA_HD: begin
                if (expire) begin
                    scl_n   = 1'b1;
                    sd_n    = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            ST_SP_LOW: begin
                if (expire) begin
                    scl_n    = 1'b0;
                    state_n  = ST_STO_SU;
                    load     = 1'b1;
                    load_val = seg_sto_su(cfg_q);
                end
            end
            ST_STO_SU: begin
                if (expire) begin
                    sda_n   = 1'b0;
                    pd_n    = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_q      <= 1'b0;
            scl_oe     <= 1'b0;
            sda_oe     <= 1'b0;
            rx_valid   <= 1'b0;
            rx_bit     <= 1'b0;
            bit_done   <= 1'b0;
            start_done <= 1'b0;
            stop_done  <= 1'b0;
        end else begin
            state      <= state_n;
            scl_oe     <= scl_n;
            sda_oe     <= sda_n;
            rx_valid   <= rxv_n;
            bit_done   <= bd_n;
            start_done <= sd_n;
            stop_done  <= pd_n;
            if (accept) begin
                bit_q <= cmd_bit;
            end
            if (rxv_n) begin
                rx_bit <= sda_in;
            end
        end
    end

    // R2: SCL stays released throughout the high phase of a bit
    a_r2_scl_free_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIGH) |-> !scl_oe);

    // R4: data line frozen while the clock line is released
    a_r4_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIGH && $past(state) == ST_HIGH) |-> $stable(sda_oe));

    // R5: completion and sample strobes never coincide
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid, bit_done, start_done, stop_done}));

    // R6: a finished START leaves both lines driven low
    a_r6_start_lines: assert property (@(posedge clk) disable iff (rst)
        start_done |-> (scl_oe && sda_oe));

    // R8: a finished STOP leaves both lines released
    a_r8_stop_lines: assert property (@(posedge clk) disable iff (rst)
        stop_done |-> (!scl_oe && !sda_oe));

endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer
    import i2c_tg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] div_word,
    input  logic [2:0]  upd_sel,
    input  logic [1:0]  sta_sel,
    input  logic [1:0]  sto_sel,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic        cmd_bit,
    output logic        cmd_ready,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        rx_valid,
    output logic        rx_bit,
    output logic        bit_done,
    output logic        start_done,
    output logic        stop_done
);

    tg_cfg_t          cfg_live, cfg_q;
    logic             accept, load, expire;
    logic [TMR_W-1:0] load_val, remain;

    tg_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .capture  (accept),
        .div_word (div_word),
        .upd_sel  (upd_sel),
        .sta_sel  (sta_sel),
        .sto_sel  (sto_sel),
        .cfg_live (cfg_live),
        .cfg_q    (cfg_q)
    );

    tg_seg_timer u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .remain   (remain),
        .expire   (expire)
    );

    tg_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (tg_op_e'(cmd_op)),
        .cmd_bit    (cmd_bit),
        .sda_in     (sda_in),
        .cfg_live   (cfg_live),
        .cfg_q      (cfg_q),
        .remain     (remain),
        .expire     (expire),
        .load       (load),
        .load_val   (load_val),
        .accept     (accept),
        .cmd_ready  (cmd_ready),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .rx_valid   (rx_valid),
        .rx_bit     (rx_bit),
        .bit_done   (bit_done),
        .start_done (start_done),
        .stop_done  (stop_done)
    );

    // R10: captured timing holds still for the whole primitive
    a_r10_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (!cmd_ready && !$past(cmd_ready)) |-> $stable(cfg_q));

    // R9: no acceptance while busy
    a_r9_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |-> !accept);

endmodule

// File: tb/i2c_phase_timer_bench.sv
module i2c_phase_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HMASK      = 1023;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] div_word = '0;
    logic [2:0]  upd_sel = '0;
    logic [1:0]  sta_sel = '0;
    logic [1:0]  sto_sel = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        cmd_bit = 1'b0;
    logic        sda_in = 1'b1;
    logic        cmd_ready, scl_oe, sda_oe, rx_valid, rx_bit;
    logic        bit_done, start_done, stop_done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic hist_scl [0:HMASK];
    logic hist_sda [0:HMASK];
    int   rx_cnt = 0, bd_cnt = 0, sd_cnt = 0, pd_cnt = 0;
    int   rx_t = 0, bd_t = 0, sd_t = 0, pd_t = 0;
    logic rx_v = 1'b0;

    i2c_phase_timer u_i2c_phase_timer (
        .clk(clk), .rst(rst), .div_word(div_word), .upd_sel(upd_sel),
        .sta_sel(sta_sel), .sto_sel(sto_sel), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cmd_ready(cmd_ready),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .bit_done(bit_done),
        .start_done(start_done), .stop_done(stop_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // record line levels and strobes after every edge
    always @(negedge clk) begin
        hist_scl[cyc & HMASK] = scl_oe;
        hist_sda[cyc & HMASK] = sda_oe;
        if (rx_valid)   begin rx_cnt++; rx_t = cyc; rx_v = rx_bit; end
        if (bit_done)   begin bd_cnt++; bd_t = cyc; end
        if (start_done) begin sd_cnt++; sd_t = cyc; end
        if (stop_done)  begin pd_cnt++; pd_t = cyc; end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic hs(input int c); return hist_scl[c & HMASK]; endfunction
    function automatic logic hd(input int c); return hist_sda[c & HMASK]; endfunction

    // apply a command with its timing, then disturb inputs while it runs
    task automatic issue(input logic [1:0] op, input logic b, input logic [31:0] dw,
                         input logic [2:0] us, input logic [1:0] ss, input logic [1:0] ps,
                         output int t_acc);
        while (!cmd_ready) @(negedge clk);
        div_word = dw; upd_sel = us; sta_sel = ss; sto_sel = ps;
        cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
        @(negedge clk);
        t_acc = cyc;
        cmd_valid = 1'b0;
        // R10: scramble timing inputs after acceptance
        div_word = $urandom; upd_sel = 3'($urandom); sta_sel = 2'($urandom); sto_sel = 2'($urandom);
        repeat (2 + $urandom % 4) @(negedge clk);
        // R9: stray request while busy
        cmd_op = 2'($urandom); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic op_bit(input logic b, input logic din, input logic [31:0] dw, input logic [2:0] us);
        int t, l, h, s, ts, tr, tf, rc, bc, sc, pc;
        logic prev, steady;
        l = int'(dw[15:0]) + 1; h = int'(dw[31:16]) + 1; s = int'(us) + 1;
        sda_in = din; prev = sda_oe;
        rc = rx_cnt; bc = bd_cnt; sc = sd_cnt; pc = pd_cnt;
        issue(2'b00, b, dw, us, 2'($urandom), 2'($urandom), t);
        ts = t + s*l; tr = t + 8*l; tf = tr + 8*h;
        chk(hd(ts - 1) == prev, "R3 sda before update point", int'(hd(ts - 1)), int'(prev));
        chk(hd(ts) == ~b, "R3 sda at update point", int'(hd(ts)), int'(~b));
        chk(hs(tr - 1) && !hs(tr), "R2 R10 scl release edge", int'(hs(tr)), 0);
        chk(!hs(tf - 1) && hs(tf), "R2 R10 scl fall after high", int'(hs(tf)), 1);
        chk(bd_cnt == bc + 1 && bd_t == tf, "R2 bit_done time", bd_t, tf);
        steady = 1'b1;
        for (int c = tr; c < tf; c++) if (hd(c) != ~b) steady = 1'b0;
        chk(steady, "R4 sda steady in high phase", int'(steady), 1);
        chk(rx_cnt == rc + 1, "R5 one sample per bit", rx_cnt - rc, 1);
        chk(rx_t == tr + 4*h, "R5 sample time", rx_t, tr + 4*h);
        chk(rx_v == din, "R5 sampled value", int'(rx_v), int'(din));
        chk(sd_cnt == sc && pd_cnt == pc, "R9 stray request ignored", sd_cnt + pd_cnt, sc + pc);
    endtask

    task automatic check_start_from(input int t0, input int h, input int u, input string tag);
        int ta, tb;
        ta = t0 + 8*h*u; tb = ta + 8*h*(u + 1);
        chk(!hd(ta - 1) && hd(ta), {tag, " sda falls after setup"}, int'(hd(ta)), 1);
        chk(!hs(tb - 1) && hs(tb), {tag, " scl falls after hold"}, int'(hs(tb)), 1);
        chk(sd_t == tb, {tag, " start_done time"}, sd_t, tb);
    endtask

    task automatic op_start(input logic [31:0] dw, input logic [1:0] ss);
        int t, rc, pc;
        rc = rx_cnt; pc = pd_cnt;
        issue(2'b01, 1'b0, dw, 3'($urandom), ss, 2'($urandom), t);
        check_start_from(t, int'(dw[31:16]) + 1, int'(ss) + 1, "R6");
        chk(rx_cnt == rc && pd_cnt == pc, "R9 R6 no extra strobes", rx_cnt + pd_cnt, rc + pc);
    endtask

    task automatic op_restart(input logic [31:0] dw, input logic [1:0] ss);
        int t, l;
        l = int'(dw[15:0]) + 1;
        issue(2'b11, 1'b0, dw, 3'($urandom), ss, 2'($urandom), t);
        chk(!hd(t), "R7 sda released at accept", int'(hd(t)), 0);
        chk(hs(t + 4*l - 1) && !hs(t + 4*l), "R7 scl release time", int'(hs(t + 4*l)), 0);
        check_start_from(t + 4*l, int'(dw[31:16]) + 1, int'(ss) + 1, "R7");
    endtask

    task automatic op_stop(input logic [31:0] dw, input logic [1:0] ps);
        int t, l, h, p, te, sc;
        l = int'(dw[15:0]) + 1; h = int'(dw[31:16]) + 1; p = int'(ps) + 1;
        sc = sd_cnt;
        issue(2'b10, 1'b0, dw, 3'($urandom), 2'($urandom), ps, t);
        te = t + 4*l + 8*h*p;
        chk(hd(t), "R8 sda driven at accept", int'(hd(t)), 1);
        chk(hs(t + 4*l - 1) && !hs(t + 4*l), "R8 scl release time", int'(hs(t + 4*l)), 0);
        chk(hd(te - 1) && !hd(te), "R8 sda release time", int'(hd(te)), 0);
        chk(pd_t == te, "R8 stop_done time", pd_t, te);
        chk(sd_cnt == sc, "R9 no start during stop", sd_cnt, sc);
    endtask

    function automatic logic [31:0] rnd_dw();
        return {16'($urandom % 6), 16'($urandom % 6)};
    endfunction

    initial begin
        #(CLK_PERIOD * 180000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R9: actual=%0d expected=0 (run hung)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R1 lines released in reset", int'(scl_oe) + int'(sda_oe), 0);
        chk(cmd_ready, "R1 ready in reset", int'(cmd_ready), 1);
        chk(!(rx_valid | bit_done | start_done | stop_done), "R1 strobes quiet", 1, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!scl_oe && !sda_oe && cmd_ready, "R1 state after reset", int'(scl_oe), 0);

        // directed corners: minimum divisors, update point at both ends
        op_start(32'h0000_0000, 2'd0);
        op_bit(1'b0, 1'b1, 32'h0000_0000, 3'd7);
        op_bit(1'b1, 1'b0, 32'h0000_0000, 3'd0);
        op_bit(1'b0, 1'b0, 32'h0003_0001, 3'd7);
        op_restart(32'h0001_0002, 2'd3);
        op_bit(1'b1, 1'b1, 32'h0002_0005, 3'd3);
        op_stop(32'h0002_0003, 2'd3);

        // random transactions
        for (int tr = 0; tr < 24; tr++) begin
            op_start(rnd_dw(), 2'($urandom));
            for (int k = 0; k < 1 + int'($urandom % 9); k++)
                op_bit(1'($urandom), 1'($urandom), rnd_dw(), 3'($urandom));
            if ($urandom % 3 == 0) begin
                op_restart(rnd_dw(), 2'($urandom));
                for (int k = 0; k < 1 + int'($urandom % 3); k++)
                    op_bit(1'($urandom), 1'($urandom), rnd_dw(), 3'($urandom));
            end
            op_stop(rnd_dw(), 2'($urandom));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule